// File: doc/BRIEF.md
# Program Counter with Return Stack

This block holds the instruction fetch pointer of a small 8-bit processor. The counter is 13 bits wide, which covers an 8K-word space. Only the bottom 8 bits are visible as a register that software can read and write. The top 5 bits cannot be written directly. Software stages them in a separate holding register, and they enter the counter only when the counter is loaded.

The block keeps an 8-entry hardware stack of return addresses. Call and interrupt entry push onto it, and every kind of return pops from it. The stack is circular: pushing past eight entries overwrites the oldest one, and no flag is raised.

The fetch address sent to program memory is the low `ADDR_W` bits of the counter. Code that runs past the implemented memory therefore wraps around to the bottom. Instruction decode drives the strobes (increment, branch, low-byte write, call, return, interrupt entry) together with the branch or call target.

Top module: `pc_unit`

## Requirements
- R1: After an asynchronous reset (`rst_ni` low), `pc_o`, `pc_lo_o`, `fetch_addr_o` and `hold_o` all read zero.
- R2: `inc_i` alone advances `pc_o` by one on the next clock edge. The 13-bit counter rolls over from 1FFFh to 0000h.
- R3: `fetch_addr_o` always equals `pc_o[ADDR_W-1:0]`, with `ADDR_W` = 11 by default. For example, counter 0800h fetches address 000h.
- R4: `hold_wr_i` stores `hold_wdata_i[4:0]`. `hold_o` returns those 5 bits with bits 7:5 read as zero.
- R5: Writing the holding register alone leaves `pc_o` unchanged. `lo_wr_i` loads `pc_o` with {holding bits 4:0, `lo_wdata_i`}.
- R5 (continued): `pc_lo_o` always shows the live `pc_o[7:0]`.
- R6: `jump_i` loads `pc_o` with {holding bits 4:3, `tgt_i[10:0]`} and leaves the stack untouched.
- R7: `call_i` pushes `pc_o`+1 and loads `pc_o` with {holding bits 4:3, `tgt_i`}.
- R8: `int_i` pushes the current `pc_o` and forces `pc_o` to 0004h.
- R9: `ret_i` loads `pc_o` with the most recently pushed entry and removes it. Nested pushes come back in last-in-first-out order.
- R10: The stack holds 8 entries in a ring. A ninth push overwrites the oldest entry. Further pops keep cycling through the ring and raise no flag.
- R11: When strobes arrive in the same cycle, the priority from highest to lowest is interrupt, return, call, jump, low-byte write, increment. Only the winning strobe acts on the counter and the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_i | input | 1 | Advance the counter by one |
| jump_i | input | 1 | Branch to target |
| call_i | input | 1 | Push return address and branch to target |
| ret_i | input | 1 | Pop the stack into the counter |
| int_i | input | 1 | Interrupt entry: push and go to vector |
| tgt_i | input | 11 | Branch or call target, low bits |
| lo_wr_i | input | 1 | Write counter low byte |
| lo_wdata_i | input | 8 | Low byte write data |
| hold_wr_i | input | 1 | Write holding register |
| hold_wdata_i | input | 8 | Holding register write data |
| pc_o | output | 13 | Full counter value |
| pc_lo_o | output | 8 | Readable low byte of the counter |
| hold_o | output | 8 | Holding register readback |
| fetch_addr_o | output | 11 | Program memory fetch address |

## Verification
The bench targets these corner cases:

- **Staging the upper bits.** A design that loaded the upper bits as soon as the holding register was written would change `pc_o` with no low-byte write.
- **Rollover.** A counter that saturated or carried wrongly would fail the rollover from 1FFFh and the 0800h fetch wrap.
- **Stack overflow.** After nine pushes, a stack that refused to overwrite or that clamped its pointer would return the wrong values on the eighth and ninth pops.
- **Simultaneous strobes.** When strobes collide, a design whose priority was wrong would do one of two things: push on call while returning, or pop while entering an interrupt. Either would shift every later return address.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [2:0] {
    SRC_KEEP,
    SRC_INC,
    SRC_LOWR,
    SRC_JUMP,
    SRC_CALL,
    SRC_RET,
    SRC_INT
  } pc_src_e;
endpackage

// File: rtl/pc_hold_reg.sv
module pc_hold_reg #(
  parameter int DATA_W = 8,
  parameter int HOLD_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [HOLD_W-1:0] hold_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD_W = DATA_W - HOLD_W;

  logic [HOLD_W-1:0] hold_q;
  logic              unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:HOLD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_q <= '0;
    else if (wr_i) hold_q <= wdata_i[HOLD_W-1:0];
  end

  assign hold_o  = hold_q;
  assign rdata_o = {{PAD_W{1'b0}}, hold_q};

  // R4
  hold_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> rdata_o == {{PAD_W{1'b0}}, $past(wdata_i[HOLD_W-1:0])});
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_dec;

  assign ptr_dec = ptr_q - PTR_W'(1);

  // ring: pointer wraps both ways, oldest slot is overwritten
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[ptr_q] <= data_i;
      ptr_q        <= ptr_q + PTR_W'(1);
    end else if (pop_i) begin
      ptr_q <= ptr_dec;
    end
  end

  assign top_o = mem_q[ptr_dec];

  // R9
  push_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(data_i));

  // R10
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/pc_unit.sv
module pc_unit
  import pc_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int ADDR_W  = 11,
  parameter int TGT_W   = 11,
  parameter int DATA_W  = 8,
  parameter int HOLD_W  = 5,
  parameter int DEPTH   = 8,
  parameter int INT_VEC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              jump_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              int_i,
  input  logic [TGT_W-1:0]  tgt_i,
  input  logic              lo_wr_i,
  input  logic [DATA_W-1:0] lo_wdata_i,
  input  logic              hold_wr_i,
  input  logic [DATA_W-1:0] hold_wdata_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [DATA_W-1:0] pc_lo_o,
  output logic [DATA_W-1:0] hold_o,
  output logic [ADDR_W-1:0] fetch_addr_o
);
  localparam int PAGE_W = PC_W - TGT_W;

  logic [PC_W-1:0]   pc_q, pc_d, pc_inc, top, push_data;
  logic [HOLD_W-1:0] hold;
  logic              push, pop;
  pc_src_e           src;

  pc_hold_reg #(.DATA_W(DATA_W), .HOLD_W(HOLD_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (hold_wr_i),
    .wdata_i (hold_wdata_i),
    .hold_o  (hold),
    .rdata_o (hold_o)
  );

  always_comb begin
    if      (int_i)   src = SRC_INT;
    else if (ret_i)   src = SRC_RET;
    else if (call_i)  src = SRC_CALL;
    else if (jump_i)  src = SRC_JUMP;
    else if (lo_wr_i) src = SRC_LOWR;
    else if (inc_i)   src = SRC_INC;
    else              src = SRC_KEEP;
  end

  assign pc_inc = pc_q + PC_W'(1);

  always_comb begin
    unique case (src)
      SRC_INT:  pc_d = PC_W'(INT_VEC);
      SRC_RET:  pc_d = top;
      SRC_CALL,
      SRC_JUMP: pc_d = {hold[HOLD_W-1 -: PAGE_W], tgt_i};
      SRC_LOWR: pc_d = {hold, lo_wdata_i};
      SRC_INC:  pc_d = pc_inc;
      default:  pc_d = pc_q;
    endcase
  end

  assign push      = (src == SRC_INT) || (src == SRC_CALL);
  assign pop       = (src == SRC_RET);
  assign push_data = (src == SRC_INT) ? pc_q : pc_inc;

  pc_ret_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .data_i (push_data),
    .top_o  (top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o         = pc_q;
  assign pc_lo_o      = pc_q[DATA_W-1:0];
  assign fetch_addr_o = pc_q[ADDR_W-1:0];

  // R8
  int_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_i |=> pc_o == PC_W'(INT_VEC));

  // R2
  inc_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !int_i && !ret_i && !call_i && !jump_i && !lo_wr_i)
      |=> pc_o == $past(pc_o) + PC_W'(1));

  // R5
  hold_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_wr_i && !int_i && !ret_i && !call_i && !jump_i && !lo_wr_i && !inc_i)
      |=> $stable(pc_o));

  // R5
  lo_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_wr_i && !int_i && !ret_i && !call_i && !jump_i)
      |=> pc_o[DATA_W-1:0] == $past(lo_wdata_i));

  // R9
  ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !int_i) |=> pc_o == $past(top));
endmodule

// File: tb/tb_pc_unit.sv
module tb_pc_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        inc_i = 0, jump_i = 0, call_i = 0, ret_i = 0, int_i = 0;
  logic [10:0] tgt_i = '0;
  logic        lo_wr_i = 0, hold_wr_i = 0;
  logic [7:0]  lo_wdata_i = '0, hold_wdata_i = '0;
  logic [12:0] pc_o;
  logic [7:0]  pc_lo_o, hold_o;
  logic [10:0] fetch_addr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pc_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .inc_i(inc_i), .jump_i(jump_i), .call_i(call_i),
    .ret_i(ret_i), .int_i(int_i), .tgt_i(tgt_i), .lo_wr_i(lo_wr_i),
    .lo_wdata_i(lo_wdata_i), .hold_wr_i(hold_wr_i), .hold_wdata_i(hold_wdata_i),
    .pc_o(pc_o), .pc_lo_o(pc_lo_o), .hold_o(hold_o), .fetch_addr_o(fetch_addr_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // apply strobes set by caller for one edge, then release
  task automatic tick();
    @(posedge clk);
    #1;
    inc_i = 0; jump_i = 0; call_i = 0; ret_i = 0; int_i = 0;
    lo_wr_i = 0; hold_wr_i = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    #3;
    @(posedge clk);
    #1;
    rst_ni = 1;
  endtask

  task automatic set_hold(input logic [7:0] v);
    hold_wr_i = 1; hold_wdata_i = v; tick();
  endtask

  task automatic wr_lo(input logic [7:0] v);
    lo_wr_i = 1; lo_wdata_i = v; tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pc", pc_o, 0);
    chk("R1 pc_lo", pc_lo_o, 0);
    chk("R1 fetch", fetch_addr_o, 0);
    chk("R1 hold", hold_o, 0);
  endtask

  task automatic t_inc();
    for (int i = 0; i < 3; i++) begin inc_i = 1; tick(); end
    chk("R2 inc x3", pc_o, 3);
  endtask

  task automatic t_hold_lo();
    set_hold(8'hFF);
    chk("R4 hold readback", hold_o, 8'h1F);
    chk("R5 hold write leaves pc", pc_o, 3);
    wr_lo(8'h34);
    chk("R5 lo write", pc_o, 13'h1F34);
    chk("R3 fetch mask", fetch_addr_o, 11'h734);
    inc_i = 1; tick();
    chk("R5 pc_lo live", pc_lo_o, 8'h35);
    wr_lo(8'hFF);
    inc_i = 1; tick();
    chk("R2 rollover", pc_o, 0);
    set_hold(8'h08);
    wr_lo(8'h00);
    chk("R3 pc 0800", pc_o, 13'h0800);
    chk("R3 fetch wraps", fetch_addr_o, 0);
  endtask

  task automatic t_jump();
    set_hold(8'h18);
    jump_i = 1; tgt_i = 11'h123; tick();
    chk("R6 jump", pc_o, 13'h1923);
    ret_i = 1; tick();
    chk("R6 jump no push", pc_o, 0);
  endtask

  task automatic t_call_ret();
    jump_i = 1; tgt_i = 11'h123; tick();
    call_i = 1; tgt_i = 11'h045; tick();
    chk("R7 call target", pc_o, 13'h1845);
    inc_i = 1; tick();
    ret_i = 1; tick();
    chk("R7 return to pc+1", pc_o, 13'h1924);
  endtask

  task automatic t_int();
    int_i = 1; tick();
    chk("R8 int vector", pc_o, 4);
    ret_i = 1; tick();
    chk("R8 int return", pc_o, 13'h1924);
    set_hold(8'h00);
    call_i = 1; tgt_i = 11'h200; tick();
    int_i = 1; tick();
    ret_i = 1; tick();
    chk("R9 nested inner", pc_o, 13'h200);
    ret_i = 1; tick();
    chk("R9 nested outer", pc_o, 13'h1925);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int k = 1; k <= 9; k++) begin
      jump_i = 1; tgt_i = 11'(k * 16); tick();
      int_i = 1; tick();
    end
    for (int k = 9; k >= 2; k--) begin
      ret_i = 1; tick();
      chk("R10 ring pop", pc_o, k * 16);
    end
    ret_i = 1; tick();
    chk("R10 ninth pop wraps", pc_o, 9 * 16);
  endtask

  task automatic t_prio();
    do_reset();
    jump_i = 1; tgt_i = 11'h100; tick();
    int_i = 1; ret_i = 1; call_i = 1; jump_i = 1; inc_i = 1; tick();
    chk("R11 int wins", pc_o, 4);
    ret_i = 1; tick();
    chk("R11 int pushed not popped", pc_o, 13'h100);
    inc_i = 1; tick();
    call_i = 1; tgt_i = 11'h200; tick();
    ret_i = 1; call_i = 1; tgt_i = 11'h300; tick();
    chk("R11 ret beats call", pc_o, 13'h102);
    call_i = 1; jump_i = 1; tgt_i = 11'h050; tick();
    chk("R11 call beats jump tgt", pc_o, 13'h050);
    ret_i = 1; tick();
    chk("R11 call pushed", pc_o, 13'h103);
    jump_i = 1; lo_wr_i = 1; tgt_i = 11'h333; lo_wdata_i = 8'h77; tick();
    chk("R11 jump beats lo", pc_o, 13'h333);
    lo_wr_i = 1; inc_i = 1; lo_wdata_i = 8'h10; tick();
    chk("R11 lo beats inc", pc_o, 13'h010);
  endtask

  initial begin
    t_reset();
    t_inc();
    t_hold_lo();
    t_jump();
    t_call_ret();
    t_int();
    t_overflow();
    t_prio();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule